// File: doc/BRIEF.md
# Synthesizer Double-Buffered Configuration Interface

This block is the programming front end of a frequency synthesizer. It holds a 20-bit primary divider word and an 8-bit enhancement byte. These can be loaded in three ways: bit by bit through a serial port, byte by byte through a parallel bus with one write strobe per field group, or, in direct mode, straight from dedicated pins. A hop strobe copies the primary word into a secondary word. A frequency-select input then picks which of the two words drives the divider controls. Firmware can therefore stage the next channel in the primary word while the secondary word is still in use, and switch channels with a single select transition.

All strobes and the serial clock are asynchronous to the block. Each one passes through a two-stage synchronizer and a rising-edge detector in the system clock domain. Registers update on the system clock edge after a rising edge has been detected. The divider word is laid out as {R[5:0], prescaler enable, M[8:0], A[3:0]}, from bit 19 down to bit 0. The prescaler enable is active low: a 1 means the prescaler is bypassed.

Top module: `synth_cfg_if`

## Requirements
- R1: The mode is decoded as follows. direct_i=1 selects direct mode whatever serial_i is. direct_i=0 with serial_i=1 selects serial mode. direct_i=0 with serial_i=0 selects parallel mode.
- R2: In serial mode with enh_wr_i low, each rising edge of ser_clk_i shifts ser_data_i into bit 0 of the primary word, and bit 19 drops out. A 20-bit word sent MSB first therefore ends up as {r[19:14], pre_en[13], m[12:4], a[3:0]}.
- R3: In serial mode with enh_wr_i high, each rising edge of ser_clk_i shifts ser_data_i into bit 0 of the enhancement byte, MSB first, and the primary word is left unchanged.
- R4: In parallel mode, a rising edge of m1_wr_i loads bus_i[7] into pre_en and bus_i[6:0] into m[6:0].
- R5: In parallel mode, a rising edge of m2_wr_i loads bus_i[3:2] into r[5:4] and bus_i[1:0] into m[8:7]. bus_i[7:4] is ignored.
- R6: In parallel mode, a rising edge of a_wr_i loads bus_i[7:4] into r[3:0] and bus_i[3:0] into a[3:0].
- R7: In parallel mode, a rising edge of enh_wr_i loads bus_i into the enhancement byte.
- R8: In serial or parallel mode, a rising edge of hop_wr_i copies the whole primary word into the secondary word. The secondary word changes at no other time.
- R9: Outside direct mode, the outputs show the primary word when the active select is 1 and the secondary word when it is 0. The active select is fsel_ser_i in serial mode and fsel_par_i in parallel mode; the other select pin has no effect.
- R10: In direct mode, m_o, a_o and pre_en_o follow dir_m_i, dir_a_i and dir_pre_en_i, and r_o is 0. Serial clocks, parallel strobes and hop strobes leave the primary, secondary and enhancement registers unchanged.
- R11: Reset clears the primary, secondary and enhancement registers to zero. A strobe held high for 4 clock cycles takes effect within those 4 cycles.
- R12: In parallel mode the serial clock has no effect on the primary word. In serial mode the parallel field strobes have no effect on the primary word or the enhancement byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_i | input | 1 | Direct mode select |
| serial_i | input | 1 | Serial (1) or parallel (0) mode select when not direct |
| ser_clk_i | input | 1 | Serial shift clock, rising edge active |
| ser_data_i | input | 1 | Serial data, MSB first |
| enh_wr_i | input | 1 | Serial: enhancement target level. Parallel: enhancement write strobe |
| fsel_ser_i | input | 1 | Word select used in serial mode |
| fsel_par_i | input | 1 | Word select used in parallel mode |
| bus_i | input | 8 | Parallel data bus |
| m1_wr_i | input | 1 | Strobe for pre_en and m[6:0] |
| m2_wr_i | input | 1 | Strobe for r[5:4] and m[8:7] |
| a_wr_i | input | 1 | Strobe for r[3:0] and a[3:0] |
| hop_wr_i | input | 1 | Copies primary into secondary |
| dir_m_i | input | 9 | Direct-mode M value |
| dir_a_i | input | 4 | Direct-mode A value |
| dir_pre_en_i | input | 1 | Direct-mode prescaler enable, active low |
| m_o | output | 9 | M counter control |
| a_o | output | 4 | A counter control |
| r_o | output | 6 | R counter control |
| pre_en_o | output | 1 | Prescaler enable, active low |
| enh_o | output | 8 | Enhancement byte |

## Verification
Some behaviours are checked by assertions on every cycle. These are the hop copy and the hold of the secondary word between hops, each serial shift into the primary word or the enhancement byte, the direct-mode pin passthrough and the freezing of the registers in that mode, the secondary-word selection, and the rule that the serial clock has no effect in parallel mode. Other behaviours can only be shown by the bench scenarios. These are the field scattering of each parallel strobe over a full sweep of bus values, the full 20-bit serial word order, the reset values, and the fact that registers written in one mode keep their values through a switch to another mode.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
  localparam int M_W    = 9;
  localparam int A_W    = 4;
  localparam int R_W    = 6;
  localparam int BUS_W  = 8;
  localparam int ENH_W  = 8;
  localparam int WORD_W = R_W + 1 + M_W + A_W;

  // strobe vector indices
  localparam int STB_SCLK = 0;
  localparam int STB_ENH  = 1;
  localparam int STB_M1   = 2;
  localparam int STB_M2   = 3;
  localparam int STB_A    = 4;
  localparam int STB_HOP  = 5;
  localparam int STB_N    = 6;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic           pre_en;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
  } cfg_word_t;

  typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_DIR = 2'd2} if_mode_e;

  function automatic if_mode_e decode_mode(input logic dir, input logic ser);
    if (dir)      return MODE_DIR;
    else if (ser) return MODE_SER;
    else          return MODE_PAR;
  endfunction
endpackage

// File: rtl/synth_cfg_edge.sv
`timescale 1ns/1ps
module synth_cfg_edge #(
  parameter int N      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], async_i[g]};
    end
    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/synth_cfg_regs.sv
`timescale 1ns/1ps
module synth_cfg_regs
  import synth_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  if_mode_e         mode_i,
  input  logic [STB_N-1:0] level_i,
  input  logic [STB_N-1:0] rise_i,
  input  logic             ser_data_i,
  input  logic [BUS_W-1:0] bus_i,
  output cfg_word_t        prim_o,
  output cfg_word_t        sec_o,
  output logic [ENH_W-1:0] enh_o
);
  localparam int M_LO_W = BUS_W - 1;            // m bits loaded by M1
  localparam int M_HI_W = M_W - M_LO_W;         // m bits loaded by M2
  localparam int R_LO_W = BUS_W - A_W;          // r bits loaded by A strobe
  localparam int R_HI_W = R_W - R_LO_W;         // r bits loaded by M2
  localparam int M2_W   = R_HI_W + M_HI_W;

  cfg_word_t        prim_q, sec_q;
  logic [ENH_W-1:0] enh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q <= '0;
      sec_q  <= '0;
      enh_q  <= '0;
    end else begin
      if (mode_i == MODE_SER && rise_i[STB_SCLK]) begin
        if (level_i[STB_ENH]) enh_q  <= {enh_q[ENH_W-2:0], ser_data_i};
        else                  prim_q <= {prim_q[WORD_W-2:0], ser_data_i};
      end
      if (mode_i == MODE_PAR) begin
        if (rise_i[STB_M1]) {prim_q.pre_en, prim_q.m[M_LO_W-1:0]} <= bus_i;
        if (rise_i[STB_M2]) {prim_q.r[R_W-1:R_LO_W], prim_q.m[M_W-1:M_LO_W]} <= bus_i[M2_W-1:0];
        if (rise_i[STB_A])  {prim_q.r[R_LO_W-1:0], prim_q.a} <= bus_i;
        if (rise_i[STB_ENH]) enh_q <= bus_i;
      end
      if (mode_i != MODE_DIR && rise_i[STB_HOP]) sec_q <= prim_q;
    end
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;
  assign enh_o  = enh_q;
endmodule

// File: rtl/synth_cfg_omux.sv
`timescale 1ns/1ps
module synth_cfg_omux
  import synth_cfg_pkg::*;
(
  input  if_mode_e       mode_i,
  input  logic           fsel_ser_i,
  input  logic           fsel_par_i,
  input  cfg_word_t      prim_i,
  input  cfg_word_t      sec_i,
  input  logic [M_W-1:0] dir_m_i,
  input  logic [A_W-1:0] dir_a_i,
  input  logic           dir_pre_en_i,
  output logic [M_W-1:0] m_o,
  output logic [A_W-1:0] a_o,
  output logic [R_W-1:0] r_o,
  output logic           pre_en_o
);
  cfg_word_t pick;
  logic      sel;

  always_comb begin
    sel  = (mode_i == MODE_SER) ? fsel_ser_i : fsel_par_i;
    pick = sel ? prim_i : sec_i;
    if (mode_i == MODE_DIR) begin
      m_o      = dir_m_i;
      a_o      = dir_a_i;
      r_o      = '0;
      pre_en_o = dir_pre_en_i;
    end else begin
      m_o      = pick.m;
      a_o      = pick.a;
      r_o      = pick.r;
      pre_en_o = pick.pre_en;
    end
  end
endmodule

// File: rtl/synth_cfg_if.sv
`timescale 1ns/1ps
module synth_cfg_if
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             direct_i,
  input  logic             serial_i,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             enh_wr_i,
  input  logic             fsel_ser_i,
  input  logic             fsel_par_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             m1_wr_i,
  input  logic             m2_wr_i,
  input  logic             a_wr_i,
  input  logic             hop_wr_i,
  input  logic [M_W-1:0]   dir_m_i,
  input  logic [A_W-1:0]   dir_a_i,
  input  logic             dir_pre_en_i,
  output logic [M_W-1:0]   m_o,
  output logic [A_W-1:0]   a_o,
  output logic [R_W-1:0]   r_o,
  output logic             pre_en_o,
  output logic [ENH_W-1:0] enh_o
);
  logic [STB_N-1:0] stb_raw, stb_level, stb_rise;
  if_mode_e         mode;
  cfg_word_t        prim_q, sec_q;
  logic [ENH_W-1:0] enh_q;

  assign mode = decode_mode(direct_i, serial_i);

  always_comb begin
    stb_raw           = '0;
    stb_raw[STB_SCLK] = ser_clk_i;
    stb_raw[STB_ENH]  = enh_wr_i;
    stb_raw[STB_M1]   = m1_wr_i;
    stb_raw[STB_M2]   = m2_wr_i;
    stb_raw[STB_A]    = a_wr_i;
    stb_raw[STB_HOP]  = hop_wr_i;
  end

  synth_cfg_edge #(.N(STB_N), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .async_i(stb_raw), .level_o(stb_level), .rise_o(stb_rise)
  );

  synth_cfg_regs u_regs (
    .clk_i, .rst_ni, .mode_i(mode), .level_i(stb_level), .rise_i(stb_rise),
    .ser_data_i, .bus_i, .prim_o(prim_q), .sec_o(sec_q), .enh_o(enh_q)
  );

  synth_cfg_omux u_omux (
    .mode_i(mode), .fsel_ser_i, .fsel_par_i, .prim_i(prim_q), .sec_i(sec_q),
    .dir_m_i, .dir_a_i, .dir_pre_en_i, .m_o, .a_o, .r_o, .pre_en_o
  );

  assign enh_o = enh_q;
endmodule

// File: rtl/synth_cfg_if_chk.sv
`timescale 1ns/1ps
module synth_cfg_if_chk
  import synth_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              direct_i,
  input logic              serial_i,
  input logic              fsel_ser_i,
  input logic              fsel_par_i,
  input logic              ser_data_i,
  input logic [M_W-1:0]    dir_m_i,
  input logic [A_W-1:0]    dir_a_i,
  input logic              dir_pre_en_i,
  input logic [STB_N-1:0]  stb_level,
  input logic [STB_N-1:0]  stb_rise,
  input logic [WORD_W-1:0] prim_q,
  input logic [WORD_W-1:0] sec_q,
  input logic [ENH_W-1:0]  enh_q,
  input logic [M_W-1:0]    m_o,
  input logic [A_W-1:0]    a_o,
  input logic [R_W-1:0]    r_o,
  input logic              pre_en_o
);
  logic hop_live, ser_mode, par_mode, act_sel;
  assign hop_live = stb_rise[STB_HOP] && !direct_i;
  assign ser_mode = !direct_i && serial_i;
  assign par_mode = !direct_i && !serial_i;
  assign act_sel  = serial_i ? fsel_ser_i : fsel_par_i;

  assert_hop_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_live |=> (sec_q == $past(prim_q)));

  assert_sec_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hop_live |=> $stable(sec_q));

  assert_ser_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && stb_rise[STB_SCLK] && !stb_level[STB_ENH])
    |=> (prim_q == {$past(prim_q[WORD_W-2:0]), $past(ser_data_i)}));

  assert_ser_enh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && stb_rise[STB_SCLK] && stb_level[STB_ENH])
    |=> ((enh_q == {$past(enh_q[ENH_W-2:0]), $past(ser_data_i)}) && $stable(prim_q)));

  assert_dir_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_i |=> ($stable(prim_q) && $stable(enh_q)));

  assert_dir_pins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_i |-> (m_o == dir_m_i && a_o == dir_a_i && pre_en_o == dir_pre_en_i && r_o == '0));

  assert_sel_sec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!direct_i && !act_sel) |-> ({r_o, pre_en_o, m_o, a_o} == sec_q));

  assert_par_no_shift_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode && !stb_rise[STB_M1] && !stb_rise[STB_M2] && !stb_rise[STB_A]) |=> $stable(prim_q));
endmodule

bind synth_cfg_if synth_cfg_if_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .direct_i(direct_i), .serial_i(serial_i),
  .fsel_ser_i(fsel_ser_i), .fsel_par_i(fsel_par_i), .ser_data_i(ser_data_i),
  .dir_m_i(dir_m_i), .dir_a_i(dir_a_i), .dir_pre_en_i(dir_pre_en_i),
  .stb_level(stb_level), .stb_rise(stb_rise), .prim_q(prim_q), .sec_q(sec_q),
  .enh_q(enh_q), .m_o(m_o), .a_o(a_o), .r_o(r_o), .pre_en_o(pre_en_o)
);

// File: tb/synth_cfg_if_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_if_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       dir = 1'b0, ser = 1'b0, sclk = 1'b0, sdata = 1'b0, enh = 1'b0;
  logic       fs = 1'b1, fp = 1'b1, m1 = 1'b0, m2 = 1'b0, aw = 1'b0, hop = 1'b0;
  logic [7:0] bus = '0;
  logic [8:0] dm = '0;
  logic [3:0] da = '0;
  logic       dpe = 1'b0;
  logic [8:0] m_o;
  logic [3:0] a_o;
  logic [5:0] r_o;
  logic       pe_o;
  logic [7:0] enh_o;

  int n_cmp = 0, n_bad = 0;
  logic [19:0] pe_w = '0, se_w = '0;   // expected primary / secondary
  logic [7:0]  ee = '0;                // expected enhancement
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_cfg_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .direct_i(dir), .serial_i(ser), .ser_clk_i(sclk),
    .ser_data_i(sdata), .enh_wr_i(enh), .fsel_ser_i(fs), .fsel_par_i(fp), .bus_i(bus),
    .m1_wr_i(m1), .m2_wr_i(m2), .a_wr_i(aw), .hop_wr_i(hop), .dir_m_i(dm), .dir_a_i(da),
    .dir_pre_en_i(dpe), .m_o(m_o), .a_o(a_o), .r_o(r_o), .pre_en_o(pe_o), .enh_o(enh_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] out_w();
    return {r_o, pe_o, m_o, a_o};
  endfunction

  task automatic set_stb(input int id, input logic v);
    case (id)
      0: sclk = v;
      1: enh  = v;
      2: m1   = v;
      3: m2   = v;
      4: aw   = v;
      default: hop = v;
    endcase
  endtask

  // high 4 cycles, low 4 cycles
  task automatic pulse(input int id);
    @(negedge clk); set_stb(id, 1'b1);
    repeat (4) @(negedge clk);
    set_stb(id, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [19:0] w, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      @(negedge clk); sdata = w[b];
      pulse(0);
    end
  endtask

  task automatic show(input logic prim_side);
    @(negedge clk);
    if (ser) fs = prim_side; else fp = prim_side;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11 act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11: reset state, both words and the enhancement byte
    show(1'b1); chk("R11 reset primary", 32'(out_w()), 32'(0));
    show(1'b0); chk("R11 reset secondary", 32'(out_w()), 32'(0));
    chk("R11 reset enh", 32'(enh_o), 32'(0));

    // R4 R5 R6 R8 R9: parallel sweep
    show(1'b1);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      @(negedge clk); bus = b; pulse(2);
      pe_w[13] = b[7]; pe_w[10:4] = b[6:0];
      b = 8'(v) ^ 8'h5A;
      @(negedge clk); bus = b; pulse(4);
      pe_w[17:14] = b[7:4]; pe_w[3:0] = b[3:0];
      b = ~8'(v);
      @(negedge clk); bus = b; pulse(3);           // R5: bus[7:4] ignored
      pe_w[19:18] = b[3:2]; pe_w[12:11] = b[1:0];
      fs = ~fs;                                    // R9: serial select ignored here
      #1 chk("R4 R5 R6 parallel fields", 32'(out_w()), 32'(pe_w));
      if (v % 32 == 31) begin
        pulse(5); se_w = pe_w;
        show(1'b0); chk("R8 R9 parallel hop secondary", 32'(out_w()), 32'(se_w));
        show(1'b1);
      end
    end

    // R7: parallel enhancement write
    for (int v = 0; v < 256; v += 3) begin
      @(negedge clk); bus = 8'(v * 7 + 1);
      pulse(1); ee = 8'(v * 7 + 1);
      chk("R7 parallel enh", 32'(enh_o), 32'(ee));
    end

    // R12: serial clock ignored in parallel mode
    shift_bits(20'hABCDE, 20);
    chk("R12 sclk ignored in parallel", 32'(out_w()), 32'(pe_w));

    // serial mode
    @(negedge clk); ser = 1'b1; fs = 1'b1; fp = 1'b0;
    #1 chk("R1 R9 serial select used", 32'(out_w()), 32'(pe_w));
    // R12: parallel strobes ignored in serial mode
    @(negedge clk); bus = 8'hC3;
    pulse(2); pulse(3); pulse(4); pulse(1);
    chk("R12 strobes ignored in serial (prim)", 32'(out_w()), 32'(pe_w));
    chk("R12 strobes ignored in serial (enh)", 32'(enh_o), 32'(ee));

    // R2 R8: serial words
    for (int i = 0; i < 40; i++) begin
      logic [19:0] w;
      w = 20'(i * 40503 + 4660);
      shift_bits(w, 20); pe_w = w;
      chk("R2 serial word", 32'(out_w()), 32'(pe_w));
      if (i % 8 == 7) begin
        pulse(5); se_w = pe_w;
        show(1'b0); chk("R8 R9 serial hop secondary", 32'(out_w()), 32'(se_w));
        show(1'b1);
      end
    end
    // R2: partial shift
    shift_bits(20'h5, 3); pe_w = {pe_w[16:0], 3'b101};
    chk("R2 partial shift", 32'(out_w()), 32'(pe_w));

    // R3: serial into enhancement
    @(negedge clk); enh = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] e;
      e = 8'(i * 53 + 17);
      shift_bits({12'd0, e}, 8); ee = e;
      chk("R3 serial enh", 32'(enh_o), 32'(ee));
      chk("R3 primary kept", 32'(out_w()), 32'(pe_w));
    end
    @(negedge clk); enh = 1'b0;
    repeat (4) @(negedge clk);

    // R10 R1: direct mode (serial_i also high)
    @(negedge clk); dir = 1'b1;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      dm = 9'(i); da = 4'(i) ^ 4'(i >> 4); dpe = 1'(i) ^ 1'(i >> 8);
      #1;
      chk("R10 direct m", 32'(m_o), 32'(dm));
      chk("R10 direct a", 32'(a_o), 32'(da));
      chk("R10 direct pre_en", 32'(pe_o), 32'(dpe));
      chk("R10 direct r zero", 32'(r_o), 32'(0));
    end
    @(negedge clk); bus = 8'hFF; sdata = 1'b1;
    pulse(0); pulse(5); ser = 1'b0; pulse(2); pulse(4); pulse(1); pulse(5);
    @(negedge clk); dir = 1'b0; fp = 1'b1;
    #1 chk("R10 primary untouched by direct", 32'(out_w()), 32'(pe_w));
    chk("R10 enh untouched by direct", 32'(enh_o), 32'(ee));
    show(1'b0); chk("R10 secondary untouched by direct", 32'(out_w()), 32'(se_w));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule